// File: doc/BRIEF.md
# Montgomery Inverse Correction Unit

This unit finishes a Montgomery-style modular inversion. An earlier engine produces a partial inverse `r` together with a power-of-two count `k`. That count is too large by `k - n`, where `n` is the exponent the caller wants to keep. The unit removes the surplus by halving modulo `p` once per clock cycle. It returns `x = a^-1 * 2^n mod p`.

A mode input selects the arithmetic. In prime-field mode, `p` is added with a carry adder. In binary-polynomial mode, `p` is XOR-ed in as a coefficient vector.

A one-cycle `start` pulse captures all operands into registers. After the last halving, `done` pulses for one cycle, and `x` holds its value until the next result.

Top module: `moninv_correct`

## Requirements
- R1: While reset is low, and on the first cycle after it, `done` is 0 and `x_out` is 0.
- R2: `start` sampled high while the unit is idle captures `r_in`, `p_in`, `k_in`, `n_in` and `gf2_mode`. When `k_in > n_in`, exactly `k_in - n_in` halving steps follow, one per cycle. `done` is then high during the cycle after clock edge `k_in - n_in + 1`, counting the capturing edge as edge 0.
- R3: A step on an even value replaces it with half of it, in both modes.
- R4: In prime-field mode (`gf2_mode` = 0), a step on an odd value replaces it with `(r + p) / 2`. The sum is formed at WIDTH+1 bits, so its carry out becomes the top bit of the result.
- R5: In polynomial mode (`gf2_mode` = 1), a step on a value whose bit 0 is 1 replaces it with `(r XOR p) >> 1`. Bit 0 is the constant coefficient, and `p` has degree below WIDTH.
- R6: When `k_in <= n_in`, no step is performed. `done` is high during the cycle after edge 1, and `x_out` equals the captured `r_in`.
- R7: `done` is high for exactly one cycle per operation. `x_out` changes only on the edge that raises `done`.
- R8: `start` is ignored while an operation is in progress. The result of the running operation is unaffected.
- R9: For odd `p` and `r_in < p`, the result satisfies `x_out * 2^(k-n) ≡ r_in (mod p)` in prime-field mode. In polynomial mode the analogous relation holds, with `z^(k-n)` in place of `2^(k-n)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| gf2_mode | input | 1 | 0 = prime field, 1 = binary polynomial field |
| r_in | input | WIDTH | Partial inverse from the first phase |
| p_in | input | WIDTH | Odd modulus or modulus polynomial |
| k_in | input | KW | Power-of-two count from the first phase |
| n_in | input | KW | Target exponent |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | WIDTH | Corrected inverse, held until the next result |

## Verification
The halving loop is tried with several operand kinds:
- Small prime moduli with mixed even and odd intermediate values, which separate the plain shift from the add-then-shift.
- A modulus close to 2^WIDTH with an odd `r`, where only a design that keeps the carry out gives the right answer.
- Polynomial vectors whose XOR and integer sum differ, which show that the mode bit changes the adder.

Zero, negative and long differences `k - n` pin down the step count. A second `start` raised mid-run shows that the captured operands are kept. Each result is compared with a behavioural model on every cycle and also checked through the congruence in R9.

// File: rtl/moninv_pkg.sv
// Shared definitions for the Montgomery inverse correction unit.
// Assumes nothing beyond a synthesizable two-state control encoding.
package moninv_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } corr_state_t;
endpackage

// File: rtl/moninv_halve_step.sv
// One conditional add-modulus-then-halve step, purely combinational.
// Assumes p is odd, so that an odd r plus p is always even. In polynomial
// mode, p must have degree below WIDTH so that the XOR fits in WIDTH bits.
module moninv_halve_step #(
    parameter int WIDTH = 32
) (
    input  logic             gf2_sel,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] modulus,
    output logic [WIDTH-1:0] nxt
);
    localparam int SUM_W = WIDTH + 1;

    logic [SUM_W-1:0] int_sum;
    logic [WIDTH-1:0] poly_sum;

    // Form both candidate sums; the integer one keeps its carry out.
    always_comb begin
        int_sum  = {1'b0, cur} + (cur[0] ? {1'b0, modulus} : {SUM_W{1'b0}});
        poly_sum = cur[0] ? (cur ^ modulus) : cur;
    end

    // Pick the field's sum and drop its (zero) low bit.
    always_comb begin
        if (gf2_sel) nxt = {1'b0, poly_sum[WIDTH-1:1]};
        else         nxt = int_sum[SUM_W-1:1];
    end
endmodule

// File: rtl/moninv_iter_ctrl.sv
// Iteration sequencer: loads the step count k - n (or zero when k <= n),
// issues one step per cycle, then a single finish cycle.
// Assumes start is a level sampled on each rising edge.
module moninv_iter_ctrl
    import moninv_pkg::*;
#(
    parameter int KW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] k_val,
    input  logic [KW-1:0] n_val,
    output logic          load,
    output logic          step_en,
    output logic          finish,
    output logic          busy
);
    corr_state_t   state_q;
    logic [KW-1:0] cnt_q;
    logic [KW-1:0] span;

    // Decode the current phase into strobes for the datapath.
    always_comb begin
        busy    = (state_q == ST_RUN);
        load    = start && (state_q == ST_IDLE);
        step_en = busy && (cnt_q != '0);
        finish  = busy && (cnt_q == '0);
        span    = (k_val > n_val) ? (k_val - n_val) : '0;
    end

    // Advance the phase and the remaining-step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= ST_RUN;
            cnt_q   <= span;
        end else if (step_en) begin
            cnt_q   <= cnt_q - 1'b1;
        end else if (finish) begin
            state_q <= ST_IDLE;
        end
    end

    // R2: each step cycle removes exactly one from the remaining count
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: a finish cycle always returns to idle
    a_r7_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);
endmodule

// File: rtl/moninv_correct.sv
// Top of the correction unit: operand registers, the step datapath, the
// sequencer, and the registered result with its done pulse.
// Assumes that p is odd and r < p. In polynomial mode, p must have degree < WIDTH.
module moninv_correct #(
    parameter int WIDTH = 32,
    parameter int KW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             gf2_mode,
    input  logic [WIDTH-1:0] r_in,
    input  logic [WIDTH-1:0] p_in,
    input  logic [KW-1:0]    k_in,
    input  logic [KW-1:0]    n_in,
    output logic             done,
    output logic [WIDTH-1:0] x_out
);
    logic             load, step_en, finish, busy;
    logic             mode_q;
    logic [WIDTH-1:0] r_q, p_q, r_next, x_q;
    logic             done_q;

    moninv_iter_ctrl #(.KW(KW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .k_val   (k_in),
        .n_val   (n_in),
        .load    (load),
        .step_en (step_en),
        .finish  (finish),
        .busy    (busy)
    );

    moninv_halve_step #(.WIDTH(WIDTH)) u_step (
        .gf2_sel (mode_q),
        .cur     (r_q),
        .modulus (p_q),
        .nxt     (r_next)
    );

    // Capture operands on start and update the working value on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            p_q    <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            r_q    <= r_in;
            p_q    <= p_in;
            mode_q <= gf2_mode;
        end else if (step_en) begin
            r_q    <= r_next;
        end
    end

    // Publish the result and raise done for one cycle at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) x_q <= r_q;
        end
    end

    assign done  = done_q;
    assign x_out = x_q;

    // R7: done never stays high for two cycles
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the result only moves together with done
    a_r7_x_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(x_out));

    // R8: a start during a run leaves the captured operands alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(p_q) && $stable(mode_q)));

    // R4: a prime-field step keeps a value below the modulus below it
    a_r4_stays_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !mode_q && (r_q < p_q)) |=> (r_q < p_q));

    // R5: a polynomial step never sets the top coefficient
    a_r5_degree_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode_q) |=> !r_q[WIDTH-1]);
endmodule

// File: tb/moninv_correct_test.sv
module moninv_correct_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          gf2_mode = 1'b0;
    logic [W-1:0]  r_in = '0, p_in = '0;
    logic [KW-1:0] k_in = '0, n_in = '0;
    logic          done;
    logic [W-1:0]  x_out;

    int tests = 0;
    int fails = 0;

    moninv_correct #(.WIDTH(W), .KW(KW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .gf2_mode(gf2_mode),
        .r_in(r_in), .p_in(p_in), .k_in(k_in), .n_in(n_in),
        .done(done), .x_out(x_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model: k - n halvings modulo p.
    function automatic longint model(input bit gf2, input longint r, input longint p, input int d);
        longint v = r;
        for (int i = 0; i < d; i++) begin
            if (v % 2 == 1) v = gf2 ? (v ^ p) : (v + p);
            v = v / 2;
        end
        return v;
    endfunction

    // Independent check: multiply back by 2^d (or z^d) and reduce.
    function automatic bit congruent(input bit gf2, input longint x, input longint r,
                                     input longint p, input int pdeg, input int d);
        longint t = x;
        for (int i = 0; i < d; i++) begin
            if (gf2) begin
                t = t << 1;
                if ((t >> pdeg) & 1) t = t ^ p;
            end else begin
                t = (t * 2) % p;
            end
        end
        return gf2 ? (t == r) : ((t % p) == (r % p));
    endfunction

    // Runs one operation and compares done/x with the model on every cycle.
    task automatic run(input bit gf2, input longint r, input longint p, input int k,
                       input int n, input int pdeg, input bit restart, input string req);
        int d = (k > n) ? k - n : 0;
        longint expx = model(gf2, r, p, d);
        longint prevx;
        @(negedge clk);
        gf2_mode = gf2; r_in = r[W-1:0]; p_in = p[W-1:0];
        k_in = k[KW-1:0]; n_in = n[KW-1:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        prevx = x_out;
        for (int j = 1; j <= d + 1; j++) begin
            if (restart && j == 1) begin
                start = 1'b1; r_in = ~r_in; p_in = 32'h3; k_in = 8'd90; gf2_mode = ~gf2;
            end
            @(negedge clk);
            start = 1'b0;
            if (j <= d) begin
                check(done == 1'b0, "R2 done early", done, 0);
                check(x_out == prevx[W-1:0], "R7 x held", x_out, prevx);
            end
        end
        check(done == 1'b1, {req, " done timing"}, done, 1);
        check(x_out == expx[W-1:0], {req, " result"}, x_out, expx);
        check(congruent(gf2, longint'(x_out), r, p, pdeg, d), "R9 congruence", x_out, expx);
        @(negedge clk);
        check(done == 1'b0, "R7 one-cycle done", done, 0);
        check(x_out == expx[W-1:0], "R7 x stays", x_out, expx);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && x_out == '0, "R1 reset state", x_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && x_out == '0, "R1 after reset", x_out, 0);
        // R3/R4: small prime, mixed parity
        run(1'b0, 64'd7, 64'd11, 9, 4, 0, 1'b0, "R3 R4 small prime");
        run(1'b0, 64'd8, 64'd13, 7, 4, 0, 1'b0, "R3 even start");
        // R4: carry out of the W-bit sum
        run(1'b0, 64'hFFFF_FFEF, 64'hFFFF_FFF1, 12, 5, 0, 1'b0, "R4 carry kept");
        // R5: polynomial mode, x^31 + x^3 + 1
        run(1'b1, 64'h1234_5679, 64'h8000_0009, 20, 8, 31, 1'b0, "R5 poly xor");
        run(1'b1, 64'h0000_0006, 64'h0000_0013, 6, 4, 4, 1'b0, "R5 poly small");
        // R6: no iterations
        run(1'b0, 64'd5, 64'd11, 4, 4, 0, 1'b0, "R6 k equals n");
        run(1'b0, 64'd9, 64'd11, 2, 6, 0, 1'b0, "R6 k below n");
        // R2: long run
        run(1'b0, 64'h0ABC_DEF1, 64'hF123_4567, 255, 0, 0, 1'b0, "R2 long run");
        // R8: start raised again mid-run
        run(1'b0, 64'd3, 64'd17, 10, 3, 0, 1'b1, "R8 restart ignored");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule